// File: doc/BRIEF.md
# I/O Permission Checker

This block decides whether the running task may execute a port input/output instruction or an interrupt-flag instruction. Each request carries the following fields:

- the instruction class;
- the 16-bit port address;
- the current privilege level of the task;
- the flags word, which holds the I/O privilege level;
- the task segment limit;
- the offset of the permission bitmap inside the task segment.

The block answers with a single-cycle response that says either allow or fault.

A task that is privileged enough for I/O is answered in one cycle. For the four port-transfer classes, an unprivileged task can still be granted access by its permission bitmap. The bitmap has one bit per port and is held in a synchronous byte-wide memory inside the block. A lookup takes a fixed number of extra cycles. During a lookup the block lowers `req_ready` and accepts no new request.

If the bitmap byte for a port lies past the task segment limit, the access faults without a lookup. It also faults without a lookup if that byte lies past the stored bitmap. The interrupt-flag classes never consult the bitmap. The bitmap contents are written through a simple byte write port.

Top module: `iop_checker_top`

## Requirements
- R1: When cur_cpl <= IOPL (numerically), every one of the six defined classes is allowed. The response (rsp_valid with rsp_allow) appears in the cycle after the request is accepted, and no bitmap lookup is made.
- R2: When cur_cpl > IOPL, classes 0 to 3 are resolved by a bitmap lookup. Bit (port mod 8) of bitmap byte (port div 8) decides the result: a 1 allows and a 0 faults. The response appears RD_LAT cycles later than a one-cycle response.
- R3: Classes 4 (clear interrupt flag) and 5 (set interrupt flag) fault in one cycle whenever cur_cpl > IOPL, whatever the bitmap holds.
- R4: IOPL is taken from bits 13:12 of the flags input. No other flags bit affects the result.
- R5: A lookup-class request with cur_cpl > IOPL faults in one cycle if map_base + (port div 8) > seg_limit.
- R6: A lookup-class request with cur_cpl > IOPL faults in one cycle if port div 8 >= MAP_DEPTH.
- R7: The class encoding is 0 in, 1 out, 2 string in, 3 string out, 4 clear interrupt flag, 5 set interrupt flag. Codes 6 and 7 fault in one cycle.
- R8: req_ready goes low in the cycle after a lookup is accepted and stays low until the response cycle. A request presented while req_ready is low produces no response.
- R9: Every response is one cycle of rsp_valid with exactly one of rsp_allow and rsp_fault set. Neither is set without rsp_valid.
- R10: A bitmap write in the same cycle that a lookup of the same byte is accepted does not affect that lookup, which sees the old byte. Later lookups see the new byte.
- R11: After reset, rsp_valid, rsp_allow and rsp_fault are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_class | input | 3 | Instruction class code |
| req_port | input | 16 | Port address |
| cur_cpl | input | 2 | Current privilege level |
| flags | input | 32 | Flags word, I/O privilege level in bits 13:12 |
| seg_limit | input | 32 | Task segment limit in bytes |
| map_base | input | 16 | Byte offset of the bitmap in the task segment |
| map_wr_en | input | 1 | Bitmap byte write enable |
| map_wr_addr | input | AW | Bitmap byte index to write |
| map_wr_data | input | 8 | Bitmap byte value |
| rsp_valid | output | 1 | Response pulse |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access faults |

## Verification
Two functions can meet in the same cycle: a bitmap byte write and the acceptance of a lookup that reads that byte. The bench provokes this by driving both in one cycle, with the written value the inverse of the old one. It then judges the first lookup against the old bit and a following lookup against the new bit. A second overlap is a request held up while a lookup is pending. The bench judges it by counting responses and requiring exactly one, which carries the lookup's result.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [2:0] {
    CLS_IN    = 3'd0,
    CLS_OUT   = 3'd1,
    CLS_INS   = 3'd2,
    CLS_OUTS  = 3'd3,
    CLS_CLRIF = 3'd4,
    CLS_SETIF = 3'd5
  } iop_class_e;

  localparam int PORT_W     = 16;
  localparam int BIT_SEL_W  = 3;
  localparam int IDX_W      = PORT_W - BIT_SEL_W;
  localparam int IOPL_LSB   = 12;

  function automatic logic is_xfer_class(input logic [2:0] c);
    return c <= 3'd3;
  endfunction

  function automatic logic is_flag_class(input logic [2:0] c);
    return (c == 3'd4) || (c == 3'd5);
  endfunction
endpackage

// File: rtl/iop_rule.sv
module iop_rule
  import iop_pkg::*;
#(
  parameter int MAP_DEPTH = 256
) (
  input  logic [2:0]        cls,
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic [31:0]       limit,
  input  logic [15:0]       base,
  output logic              need_lookup,
  output logic              fast_allow
);
  logic [IDX_W-1:0] idx;
  logic [16:0]      byte_addr;
  logic             past_limit;
  logic             past_map;
  logic             priv_ok;

  always_comb begin
    idx        = port[PORT_W-1:BIT_SEL_W];
    byte_addr  = {1'b0, base} + {4'b0, idx};
    past_limit = {15'b0, byte_addr} > limit;
    past_map   = {19'b0, idx} >= 32'(MAP_DEPTH);
    priv_ok    = cpl <= iopl;
    fast_allow  = priv_ok && (is_xfer_class(cls) || is_flag_class(cls));
    need_lookup = !priv_ok && is_xfer_class(cls) && !past_limit && !past_map;
  end
endmodule

// File: rtl/iop_map_ram.sv
module iop_map_ram #(
  parameter int DEPTH  = 256,
  parameter int RD_LAT = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  logic [7:0] stage [RD_LAT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) stage[0] <= mem[raddr];
  end

  generate
    for (genvar j = 1; j < RD_LAT; j++) begin : g_pipe
      always_ff @(posedge clk) stage[j] <= stage[j-1];
    end
  endgenerate

  assign rdata = stage[RD_LAT-1];
endmodule

// File: rtl/iop_checker_top.sv
module iop_checker_top
  import iop_pkg::*;
#(
  parameter int MAP_DEPTH = 256,
  parameter int RD_LAT    = 2,
  localparam int AW       = $clog2(MAP_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_class,
  input  logic [15:0]   req_port,
  input  logic [1:0]    cur_cpl,
  input  logic [31:0]   flags,
  input  logic [31:0]   seg_limit,
  input  logic [15:0]   map_base,
  input  logic          map_wr_en,
  input  logic [AW-1:0] map_wr_addr,
  input  logic [7:0]    map_wr_data,
  output logic          rsp_valid,
  output logic          rsp_allow,
  output logic          rsp_fault
);
  localparam int CW = $clog2(RD_LAT + 1);

  logic                 need_lookup;
  logic                 fast_allow;
  logic                 accept;
  logic                 busy;
  logic [CW-1:0]        wait_cnt;
  logic [BIT_SEL_W-1:0] bit_sel;
  logic [7:0]           map_byte;
  logic [1:0]           iopl;

  assign iopl      = flags[IOPL_LSB+1:IOPL_LSB];
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  iop_rule #(.MAP_DEPTH(MAP_DEPTH)) u_rule (
    .cls         (req_class),
    .port        (req_port),
    .cpl         (cur_cpl),
    .iopl        (iopl),
    .limit       (seg_limit),
    .base        (map_base),
    .need_lookup (need_lookup),
    .fast_allow  (fast_allow)
  );

  iop_map_ram #(.DEPTH(MAP_DEPTH), .RD_LAT(RD_LAT)) u_ram (
    .clk   (clk),
    .we    (map_wr_en),
    .waddr (map_wr_addr),
    .wdata (map_wr_data),
    .re    (accept && need_lookup),
    .raddr (req_port[AW+BIT_SEL_W-1:BIT_SEL_W]),
    .rdata (map_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      wait_cnt  <= '0;
      bit_sel   <= '0;
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
      if (busy) begin
        if (wait_cnt == CW'(RD_LAT)) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_allow <= map_byte[bit_sel];
          rsp_fault <= !map_byte[bit_sel];
        end else begin
          wait_cnt <= wait_cnt + CW'(1);
        end
      end else if (accept) begin
        if (need_lookup) begin
          busy     <= 1'b1;
          wait_cnt <= CW'(1);
          bit_sel  <= req_port[BIT_SEL_W-1:0];
        end else begin
          rsp_valid <= 1'b1;
          rsp_allow <= fast_allow;
          rsp_fault <= !fast_allow;
        end
      end
    end
  end
endmodule

// File: rtl/iop_checker_sva.sv
module iop_checker_sva #(
  parameter int MAP_DEPTH = 256,
  localparam int AW       = $clog2(MAP_DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_class,
  input logic [15:0]   req_port,
  input logic [1:0]    cur_cpl,
  input logic [31:0]   flags,
  input logic [31:0]   seg_limit,
  input logic [15:0]   map_base,
  input logic          rsp_valid,
  input logic          rsp_allow,
  input logic          rsp_fault
);
  logic        acc;
  logic        low_priv;
  logic [16:0] baddr;
  assign acc      = req_valid && req_ready;
  assign low_priv = cur_cpl > flags[13:12];
  assign baddr    = {1'b0, map_base} + {4'b0, req_port[15:3]};

  a_r1_privileged_allow: assert property (@(posedge clk) disable iff (rst)
    acc && !low_priv && req_class <= 3'd5 |=> rsp_valid && rsp_allow);

  a_r3_flag_fault: assert property (@(posedge clk) disable iff (rst)
    acc && low_priv && (req_class == 3'd4 || req_class == 3'd5) |=> rsp_valid && rsp_fault);

  a_r5_limit_fault: assert property (@(posedge clk) disable iff (rst)
    acc && low_priv && req_class <= 3'd3 && ({15'b0, baddr} > seg_limit) |=> rsp_valid && rsp_fault);

  a_r7_reserved_fault: assert property (@(posedge clk) disable iff (rst)
    acc && req_class >= 3'd6 |=> rsp_valid && rsp_fault);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    acc && low_priv && req_class <= 3'd3 && ({15'b0, baddr} <= seg_limit)
        && ({19'b0, req_port[15:3]} < 32'(MAP_DEPTH)) |=> !req_ready && !rsp_valid);

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_allow, rsp_fault}) == (rsp_valid ? 1 : 0));
endmodule

bind iop_checker_top iop_checker_sva #(.MAP_DEPTH(MAP_DEPTH)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_class(req_class), .req_port(req_port), .cur_cpl(cur_cpl), .flags(flags),
  .seg_limit(seg_limit), .map_base(map_base), .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow), .rsp_fault(rsp_fault)
);

// File: tb/test_iop_checker_top.sv
`timescale 1ns/1ps
module test_iop_checker_top;
  localparam int MAP_DEPTH = 256;
  localparam int RD_LAT    = 2;
  localparam int AW        = $clog2(MAP_DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_class = '0;
  logic [15:0] req_port = '0;
  logic [1:0] cur_cpl = '0;
  logic [31:0] flags = '0;
  logic [31:0] seg_limit = '0;
  logic [15:0] map_base = '0;
  logic map_wr_en = 1'b0;
  logic [AW-1:0] map_wr_addr = '0;
  logic [7:0] map_wr_data = '0;
  logic rsp_valid, rsp_allow, rsp_fault;

  logic [7:0] model [MAP_DEPTH];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  iop_checker_top #(.MAP_DEPTH(MAP_DEPTH), .RD_LAT(RD_LAT)) i_iop_checker_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_port(req_port), .cur_cpl(cur_cpl), .flags(flags),
    .seg_limit(seg_limit), .map_base(map_base), .map_wr_en(map_wr_en),
    .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_fault(rsp_fault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_allow(input logic [2:0] c, input logic [15:0] p,
      input logic [1:0] cpl, input logic [1:0] iopl, input logic [15:0] b, input logic [31:0] lim);
    int idx = int'(p >> 3);
    if (c > 3'd5) return 1'b0;
    if (cpl <= iopl) return 1'b1;
    if (c >= 3'd4) return 1'b0;
    if (int'(b) + idx > lim) return 1'b0;
    if (idx >= MAP_DEPTH) return 1'b0;
    return model[idx][p[2:0]];
  endfunction

  function automatic logic exp_lookup(input logic [2:0] c, input logic [15:0] p,
      input logic [1:0] cpl, input logic [1:0] iopl, input logic [15:0] b, input logic [31:0] lim);
    int idx = int'(p >> 3);
    return c <= 3'd3 && cpl > iopl && (int'(b) + idx <= lim) && idx < MAP_DEPTH;
  endfunction

  task automatic do_req(input string tag, input logic [2:0] c, input logic [15:0] p,
      input logic [1:0] cpl, input logic [1:0] iopl, input logic [15:0] b, input logic [31:0] lim,
      input logic [31:0] fl_noise);
    logic ea, el;
    int n;
    ea = exp_allow(c, p, cpl, iopl, b, lim);
    el = exp_lookup(c, p, cpl, iopl, b, lim);
    req_valid = 1'b1; req_class = c; req_port = p; cur_cpl = cpl;
    flags = (fl_noise & ~32'h3000) | (32'(iopl) << 12);
    map_base = b; seg_limit = lim;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    if (el) check({tag, " R8 ready low"}, 32'(req_ready), 32'd0);
    while (!rsp_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check({tag, " latency R1/R2"}, n, el ? RD_LAT : 0);
    check({tag, " allow R2"}, 32'(rsp_allow), 32'(ea));
    check({tag, " fault R9"}, 32'(rsp_fault), 32'(!ea));
  endtask

  task automatic write_byte(input int idx, input logic [7:0] v);
    map_wr_en = 1'b1; map_wr_addr = AW'(idx); map_wr_data = v;
    @(posedge clk);
    @(negedge clk);
    map_wr_en = 1'b0;
    model[idx] = v;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11 rsp_valid", 32'(rsp_valid), 0);
    check("R11 rsp_allow", 32'(rsp_allow), 0);
    check("R11 rsp_fault", 32'(rsp_fault), 0);
    check("R11 req_ready", 32'(req_ready), 1);

    for (int i = 0; i < MAP_DEPTH; i++) write_byte(i, 8'($urandom));

    // directed: R1 all classes privileged, R3 flag classes, R7 reserved
    for (int c = 0; c < 8; c++) do_req("R1 R7 priv", 3'(c), 16'h0123, 2'd1, 2'd2, 16'd0, 32'hFFFF, 32'h0);
    write_byte(9, 8'hFF);
    do_req("R3 clrif", 3'd4, 16'd72, 2'd3, 2'd0, 16'd0, 32'hFFFF, 32'h0);
    do_req("R3 setif", 3'd5, 16'd72, 2'd3, 2'd0, 16'd0, 32'hFFFF, 32'h0);
    // R2 bit set and clear
    write_byte(4, 8'b0010_0000);
    do_req("R2 bit one", 3'd1, 16'd37, 2'd3, 2'd1, 16'd0, 32'hFFFF, 32'h0);
    do_req("R2 bit zero", 3'd1, 16'd36, 2'd3, 2'd1, 16'd0, 32'hFFFF, 32'h0);
    // R4: other flags bits don't matter
    do_req("R4 noise", 3'd0, 16'd37, 2'd3, 2'd1, 16'd0, 32'hFFFF, 32'hFFFF_CFFF);
    do_req("R4 iopl3", 3'd0, 16'd36, 2'd3, 2'd3, 16'd0, 32'hFFFF, 32'h0);
    // R5 limit boundary: byte exactly at limit vs one past
    write_byte(10, 8'hFF);
    do_req("R5 at limit", 3'd2, 16'd80, 2'd2, 2'd0, 16'd100, 32'd110, 32'h0);
    do_req("R5 past limit", 3'd2, 16'd80, 2'd2, 2'd0, 16'd100, 32'd109, 32'h0);
    // R6 beyond stored bitmap
    write_byte(MAP_DEPTH-1, 8'hFF);
    do_req("R6 last byte", 3'd3, 16'((MAP_DEPTH-1)*8), 2'd3, 2'd0, 16'd0, 32'hFFFF, 32'h0);
    do_req("R6 past map", 3'd3, 16'(MAP_DEPTH*8), 2'd3, 2'd0, 16'd0, 32'hFFFF, 32'h0);

    // R8: request presented while busy is ignored
    begin
      int nresp;
      logic ea;
      write_byte(6, 8'h08);
      ea = 1'b1;
      req_valid = 1'b1; req_class = 3'd0; req_port = 16'd51; cur_cpl = 2'd3;
      flags = 32'h0; map_base = 16'd0; seg_limit = 32'hFFFF;
      @(posedge clk);
      @(negedge clk);
      req_class = 3'd4; req_port = 16'd0; cur_cpl = 2'd3;
      nresp = 0;
      for (int k = 0; k < RD_LAT + 3; k++) begin
        if (rsp_valid) begin
          nresp++;
          check("R8 busy result", 32'(rsp_allow), 32'(ea));
          req_valid = 1'b0;
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
      check("R8 one response", nresp, 1);
      @(negedge clk);
      check("R8 no late response", 32'(rsp_valid), 0);
    end

    // R10: write and lookup of the same byte in one cycle
    begin
      logic [7:0] oldv;
      int n;
      oldv = model[5];
      map_wr_en = 1'b1; map_wr_addr = AW'(5); map_wr_data = ~oldv;
      req_valid = 1'b1; req_class = 3'd1; req_port = 16'd43; cur_cpl = 2'd3;
      flags = 32'h0; map_base = 16'd0; seg_limit = 32'hFFFF;
      @(posedge clk);
      @(negedge clk);
      map_wr_en = 1'b0; req_valid = 1'b0;
      model[5] = ~oldv;
      n = 0;
      while (!rsp_valid && n < 20) begin
        @(negedge clk);
        n++;
      end
      check("R10 old byte seen", 32'(rsp_allow), 32'(oldv[3]));
      do_req("R10 new byte seen", 3'd1, 16'd43, 2'd3, 2'd0, 16'd0, 32'hFFFF, 32'h0);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] p, b;
      logic [31:0] lim;
      p = 16'($urandom_range(0, (MAP_DEPTH + 16) * 8 - 1));
      b = 16'($urandom_range(0, 63));
      lim = ($urandom_range(0, 3) == 0) ? 32'($urandom)
            : 32'(int'(b) + int'(p >> 3) + $urandom_range(0, 8) - 4);
      if ($urandom_range(0, 15) == 0) write_byte($urandom_range(0, MAP_DEPTH-1), 8'($urandom));
      do_req("rand", 3'($urandom), p, 2'($urandom), 2'($urandom), b, lim, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule